// File: doc/BRIEF.md
# Tapped Delay Line with Flush-Guarded Tap Update

This block delays a single data bit by a selectable number of clock cycles. The bit passes through a chain of one-cycle storage stages, and a tap address picks which stage feeds the output. Tap 0 gives a delay of one cycle, and tap N gives a delay of N+1 cycles.

Changing the tap while transitions are still travelling along the chain could put a false edge or a dropped pulse on the output. The block avoids this by holding a requested tap in a pending register. It moves the request to the active tap only after the input has stayed at one level long enough to fill the whole chain with that level. Each time the tap changes, a ready flag drops for a fixed settling interval, so the consumer knows when the new delay can be trusted.

Top module: `tap_delay_line`

## Requirements
- R1: While reset is held and directly after it, `dout` is 0, `cur_addr` is 0 and `tap_ready` is 1.
- R2: With active tap N, the value of `dout` after a clock edge equals the `din` value sampled N edges earlier than that edge. This is a delay of N+1 cycles, measured from the cycle in which `din` is driven.
- R3: `req_addr` is captured on any edge where `req_load` is 1 and is held as pending until it is applied. A later request replaces an earlier one that has not yet been applied.
- R4: An idle count returns to 0 on every edge where `din` differs from its previous sample. A pending tap is never applied while this count is below DEPTH.
- R5: If `din` stays constant after its last change, the pending tap becomes active at edge DEPTH+1 after the edge of that change. If the line is already idle when the request is captured, the tap becomes active at the edge after the capture.
- R6: `tap_ready` is 0 directly after the edge that applies a tap. It stays 0 for exactly SETTLE cycles and returns to 1 after edge SETTLE following the applying edge.
- R7: When a tap is applied on an idle line, `dout` keeps the idle level until new input data reaches the new tap.
- R8: The idle count saturates at DEPTH and does not wrap. After an arbitrarily long idle stretch, a captured request is applied at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage advances on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Data bit entering the chain |
| req_addr | input | AW = log2(DEPTH) | Requested tap |
| req_load | input | 1 | Captures `req_addr` as the pending tap |
| dout | output | 1 | Delayed data from the active tap |
| cur_addr | output | AW | Tap currently driving `dout` |
| tap_ready | output | 1 | High when the active delay has settled |

## Verification
The bench builds the block with DEPTH=16 and SETTLE=3. With these values the idle count reaches saturation within 16 cycles, and its 5-bit register would wrap after 32 cycles, so a 60-cycle idle stretch shows that it saturates instead. The whole tap range from 0 to 15 can be streamed against a history of the input. The bench measures the exact edge at which a request is applied in three situations: after a toggling stretch, on an already idle line, and after a single late change. In each case it also follows `tap_ready` through its settling window.

// File: rtl/tdl_pkg.sv
`timescale 1ns/1ps
package tdl_pkg;

  // Next idle count: restart on any input movement, otherwise climb to the limit and stay.
  function automatic int unsigned idle_step(input int unsigned cnt, input logic moved,
                                            input int unsigned lim);
    if (moved) return 0;
    if (cnt >= lim) return lim;
    return cnt + 1;
  endfunction

  // Next settle count: reload on a tap change, otherwise count down to zero.
  function automatic int unsigned settle_step(input int unsigned cnt, input logic load,
                                              input int unsigned len);
    if (load) return len;
    if (cnt == 0) return 0;
    return cnt - 1;
  endfunction

endpackage

// File: rtl/tdl_stage_chain.sv
`timescale 1ns/1ps
module tdl_stage_chain #(
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] taps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taps[0] <= 1'b0;
    else        taps[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taps[g] <= 1'b0;
      else        taps[g] <= taps[g-1];
    end
  end
endmodule

// File: rtl/tdl_idle_tracker.sv
`timescale 1ns/1ps
module tdl_idle_tracker
  import tdl_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic          prev_bit,
  output logic [CW-1:0] idle_cnt,
  output logic          idle_full
);
  logic moved;
  assign moved = din ^ prev_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_cnt <= '0;
    else        idle_cnt <= CW'(idle_step(32'(idle_cnt), moved, DEPTH));
  end

  assign idle_full = (idle_cnt == CW'(DEPTH));
endmodule

// File: rtl/tdl_tap_ctrl.sv
`timescale 1ns/1ps
module tdl_tap_ctrl
  import tdl_pkg::*;
#(
  parameter int AW     = 8,
  parameter int SETTLE = 4,
  localparam int SW = $clog2(SETTLE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_load,
  input  logic [AW-1:0] req_addr,
  input  logic          idle_full,
  output logic [AW-1:0] cur_addr,
  output logic          pending,
  output logic          apply_evt,
  output logic          tap_ready
);
  logic [AW-1:0] pend_addr;
  logic [SW-1:0] settle_cnt;

  assign apply_evt = pending && idle_full;
  assign tap_ready = (settle_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr <= '0;
      pending   <= 1'b0;
    end else if (req_load) begin
      pend_addr <= req_addr;
      pending   <= 1'b1;
    end else if (apply_evt) begin
      pending   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr   <= '0;
      settle_cnt <= '0;
    end else begin
      if (apply_evt) cur_addr <= pend_addr;
      settle_cnt <= SW'(settle_step(32'(settle_cnt), apply_evt, SETTLE));
    end
  end
endmodule

// File: rtl/tap_delay_line.sv
`timescale 1ns/1ps
module tap_delay_line #(
  parameter int DEPTH  = 256,
  parameter int SETTLE = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [AW-1:0] req_addr,
  input  logic          req_load,
  output logic          dout,
  output logic [AW-1:0] cur_addr,
  output logic          tap_ready
);
  logic [DEPTH-1:0] taps;
  logic [CW-1:0]    idle_cnt;
  logic             idle_full;
  logic             pending;
  logic             apply_evt;

  tdl_stage_chain #(.DEPTH(DEPTH)) u_chain (
    .clk(clk), .rst_n(rst_n), .din(din), .taps(taps)
  );

  tdl_idle_tracker #(.DEPTH(DEPTH)) u_idle (
    .clk(clk), .rst_n(rst_n), .din(din), .prev_bit(taps[0]),
    .idle_cnt(idle_cnt), .idle_full(idle_full)
  );

  tdl_tap_ctrl #(.AW(AW), .SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_load(req_load), .req_addr(req_addr),
    .idle_full(idle_full), .cur_addr(cur_addr), .pending(pending),
    .apply_evt(apply_evt), .tap_ready(tap_ready)
  );

  assign dout = taps[cur_addr];
endmodule

// File: rtl/tdl_checker.sv
`timescale 1ns/1ps
module tdl_checker #(
  parameter int DEPTH  = 256,
  parameter int SETTLE = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          din,
  input logic [AW-1:0] cur_addr,
  input logic          tap_ready,
  input logic [CW-1:0] idle_cnt,
  input logic          pending,
  input logic          apply_evt
);
  logic past_ok;
  int   low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      low_run <= 0;
    end else begin
      past_ok <= 1'b1;
      if (apply_evt)       low_run <= 0;
      else if (!tap_ready) low_run <= low_run + 1;
      else                 low_run <= 0;
    end
  end

  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_addr) |-> ($past(idle_cnt) == CW'(DEPTH)));

  p_idle_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (din != $past(din))) |=> (idle_cnt == '0));

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idle_cnt <= CW'(DEPTH));

  p_pend_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !apply_evt) |=> pending);

  p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    apply_evt |=> !tap_ready);

  p_settle_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= SETTLE);
endmodule

bind tap_delay_line tdl_checker #(.DEPTH(DEPTH), .SETTLE(SETTLE)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .cur_addr(cur_addr), .tap_ready(tap_ready),
  .idle_cnt(idle_cnt), .pending(pending), .apply_evt(apply_evt)
);

// File: tb/sim_tap_delay_line.sv
`timescale 1ns/1ps
module sim_tap_delay_line;
  localparam int DEPTH  = 16;
  localparam int SETTLE = 3;
  localparam int AW     = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          din = 1'b0;
  logic          req_load = 1'b0;
  logic [AW-1:0] req_addr = '0;
  wire           dout;
  wire [AW-1:0]  cur_addr;
  wire           tap_ready;

  int          e = 63;
  int          model_tap = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          hist [4096];
  logic [15:0] lfsr = 16'hACE1;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tap_delay_line #(.DEPTH(DEPTH), .SETTLE(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .req_addr(req_addr), .req_load(req_load),
    .dout(dout), .cur_addr(cur_addr), .tap_ready(tap_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", tag, e, act, exp);
    end
  endtask

  function automatic bit rnd_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  // One clock: drive inputs, wait for the edge, then compare dout with the input history (R2).
  task automatic tick(input bit v, input bit ld, input int a);
    din = v; req_load = ld; req_addr = AW'(a);
    hist[e+1] = v;
    @(posedge clk);
    e++;
    #5;
    chk(dout === hist[e - model_tap], "R2 dout vs history", int'(dout), int'(hist[e - model_tap]));
  endtask

  task automatic t_reset;
    chk(dout === 1'b0, "R1 dout in reset", int'(dout), 0);
    chk(cur_addr === '0, "R1 cur_addr in reset", int'(cur_addr), 0);
    chk(tap_ready === 1'b1, "R1 tap_ready in reset", int'(tap_ready), 1);
    @(posedge clk); #5;
    rst_n = 1'b1;
    @(posedge clk); #5;
    e++;
    chk(dout === 1'b0, "R1 dout after reset", int'(dout), 0);
    chk(cur_addr === '0, "R1 cur_addr after reset", int'(cur_addr), 0);
    chk(tap_ready === 1'b1, "R1 tap_ready after reset", int'(tap_ready), 1);
  endtask

  task automatic t_tap0_stream;
    for (int i = 0; i < 30; i++) tick(rnd_bit(), 1'b0, 0);
  endtask

  task automatic t_idle_request;
    for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 0);
    chk(tap_ready === 1'b1, "R6 ready before update", int'(tap_ready), 1);
    tick(1'b1, 1'b1, 5);
    chk(cur_addr === AW'(0), "R5 old tap at capture edge", int'(cur_addr), 0);
    model_tap = 5;
    tick(1'b1, 1'b0, 0);
    chk(cur_addr === AW'(5), "R5 idle apply next edge", int'(cur_addr), 5);
    chk(dout === 1'b1, "R7 idle level kept", int'(dout), 1);
    for (int k = 1; k < SETTLE; k++) begin
      chk(tap_ready === 1'b0, "R6 ready low in window", int'(tap_ready), 0);
      tick(1'b1, 1'b0, 0);
      chk(dout === 1'b1, "R7 idle level kept", int'(dout), 1);
    end
    chk(tap_ready === 1'b0, "R6 ready low last cycle", int'(tap_ready), 0);
    tick(1'b1, 1'b0, 0);
    chk(tap_ready === 1'b1, "R6 ready back after SETTLE", int'(tap_ready), 1);
  endtask

  task automatic t_busy_request;
    for (int i = 0; i < 40; i++) begin
      tick(~din, (i == 5) || (i == 20), (i == 5) ? 9 : 12);
      chk(cur_addr === AW'(5), "R4 tap held while toggling", int'(cur_addr), 5);
    end
    for (int k = 1; k <= DEPTH; k++) begin
      tick(din, 1'b0, 0);
      chk(cur_addr === AW'(5), "R4 tap held before flush", int'(cur_addr), 5);
    end
    model_tap = 12;
    tick(din, 1'b0, 0);
    chk(cur_addr === AW'(12), "R3 R5 last request applied at DEPTH+1", int'(cur_addr), 12);
    chk(tap_ready === 1'b0, "R6 ready drops on apply", int'(tap_ready), 0);
  endtask

  task automatic t_stream_max;
    for (int i = 0; i < 5; i++) tick(din, 1'b0, 0);
    tick(din, 1'b1, DEPTH - 1);
    model_tap = DEPTH - 1;
    tick(din, 1'b0, 0);
    chk(cur_addr === AW'(DEPTH - 1), "R5 max tap applied", int'(cur_addr), DEPTH - 1);
    for (int i = 0; i < 50; i++) tick(rnd_bit(), 1'b0, 0);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 60; i++) tick(1'b0, 1'b0, 0);
    tick(1'b0, 1'b1, 2);
    chk(cur_addr === AW'(DEPTH - 1), "R8 old tap at capture", int'(cur_addr), DEPTH - 1);
    model_tap = 2;
    tick(1'b0, 1'b0, 0);
    chk(cur_addr === AW'(2), "R8 saturated count applies at once", int'(cur_addr), 2);
  endtask

  task automatic t_change_resets;
    for (int i = 0; i < 5; i++) tick(din, 1'b0, 0);
    tick(~din, 1'b0, 0);
    tick(din, 1'b1, 7);
    chk(cur_addr === AW'(2), "R4 held after late change", int'(cur_addr), 2);
    for (int k = 2; k <= DEPTH; k++) begin
      tick(din, 1'b0, 0);
      chk(cur_addr === AW'(2), "R4 held after late change", int'(cur_addr), 2);
    end
    model_tap = 7;
    tick(din, 1'b0, 0);
    chk(cur_addr === AW'(7), "R4 R5 applied DEPTH+1 after change", int'(cur_addr), 7);
    for (int i = 0; i < 20; i++) tick(rnd_bit(), 1'b0, 0);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    #3;
    t_reset();
    t_tap0_stream();
    t_idle_request();
    t_busy_request();
    t_stream_max();
    t_saturate();
    t_change_resets();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule